// File: doc/BRIEF.md
# Simultaneous-Sample Channel Conversion Sequencer

This block is the control half of a four-channel converter whose inputs are all sampled at one common instant. A rising edge on the convert-start input moves every sample-and-hold control into hold at once and raises busy. The block then walks through the chosen subset of channels from the lowest number to the highest. For each channel it hands a channel index and a one-cycle start strobe to an external conversion engine, waits a fixed number of clock cycles, and drops an active-low end-of-conversion flag for one cycle. After the last chosen channel, busy falls and all holds return to track together.

The channel subset comes from one of two sources, chosen by a mode input: four hardware select pins, or a small register loaded over a data bus with chip-select, write and read strobes. The mux output follows its source freely while idle and is frozen at convert-start, so edits made during a sequence only count at the next start. In register mode, select pins 1 and 2 take on clock duties and are passed out as an external clock and a clock-source choice. Pins 3 and 4 are then ignored.

Top module: `ssq_sequencer`

## Requirements
- R1: Out of reset, busy is low, all hold controls are 0 (track), the end-of-conversion flag is high and the engine start strobe is low.
- R2: In the cycle after a rising edge of convert-start is seen while idle, busy is high and every hold control is 1 (hold).
- R3: Selected channels are handed to the engine in ascending order, one start strobe each. The channel index output is 0 for channel 1 through 3 for channel 4.
- R4: The end-of-conversion flag goes low for exactly one cycle, CONV_CYCLES cycles after the start strobe for that channel. There is one such pulse per selected channel.
- R5: Busy stays high through the last end-of-conversion pulse and falls one cycle later. With k channels selected it stays high for k*(CONV_CYCLES+1)+1 cycles. The hold controls return to 0 together with busy.
- R6: With the mode input at 0 the selection is taken from the select pins. With it at 1 the selection is taken from the channel register. Bit i of either source selects channel i+1.
- R7: The register loads bus data bits 0..3 (bit 0 = channel 1) when the write strobe rises after being low while chip-select is low and read is high. It keeps that value until the next such write.
- R8: A write strobe issued while chip-select is high, or while read is low, leaves the register unchanged.
- R9: The selection is frozen at convert-start. Changing the pins or mode during a sequence does not change the channels converted.
- R10: A convert-start edge that arrives while busy is high is ignored. It neither restarts nor extends the sequence.
- R11: An all-zero frozen selection gives a busy pulse of exactly one cycle, with no engine strobes and no end-of-conversion pulses.
- R12: In register mode, the external clock output equals select pin 1 and the clock-source output equals select pin 2, and pins 3 and 4 have no effect on the selection. In pin mode both clock outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Convert-start; a rising edge begins a sequence |
| sel_mode_i | input | 1 | 0: select pins, 1: channel register |
| sel_pins_i | input | NUM_CH | Hardware channel select pins, bit 0 = channel 1 |
| bus_cs_n_i | input | 1 | Active-low chip-select |
| bus_wr_n_i | input | 1 | Active-low write strobe |
| bus_rd_n_i | input | 1 | Active-low read strobe |
| bus_data_i | input | NUM_CH | Data bus bits carrying the channel mask |
| hold_o | output | NUM_CH | Sample-and-hold controls, 1 = hold |
| busy_o | output | 1 | High for the whole sequence |
| eoc_n_o | output | 1 | Active-low one-cycle end-of-conversion pulse |
| eng_start_o | output | 1 | One-cycle start strobe to the conversion engine |
| chan_idx_o | output | IDX_W | Channel being converted, 0-based |
| ext_clk_o | output | 1 | Select pin 1 passed out in register mode |
| clk_src_ext_o | output | 1 | Select pin 2 passed out in register mode |

## Verification
The ordering logic is exercised with scattered masks (channels 1, 3, 4), a lone top channel, the full set and the empty set. These show whether the lowest-set-bit search skips gaps, stops at the top, runs through every channel, and ends at once when nothing is chosen. Register-mode patterns pair a select-pin value with a different register value, so a wrong source choice shows up as a different channel order. Directed runs then check the frozen selection and a second start during busy. In both, the pass criterion is an unchanged order and an unchanged busy length.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
   timeunit 1ns;
   timeprecision 100ps;

   // Sequencer phases: waiting, choosing next channel, timing a conversion
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PICK = 2'd1,
      ST_CONV = 2'd2
   } step_t;
endpackage

// File: rtl/ssq_sel_reg.sv
module ssq_sel_reg #(
   parameter int NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              wr_n,
   input  logic              rd_n,
   input  logic [NUM_CH-1:0] data,
   output logic [NUM_CH-1:0] sel_reg
);
   timeunit 1ns;
   timeprecision 100ps;

   logic [NUM_CH-1:0] stage_q;
   logic              armed_q;
   logic              wr_q;
   logic              wr_active;
   logic              wr_rise;

   assign wr_active = !cs_n && !wr_n && rd_n;
   assign wr_rise   = wr_n && !wr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_reg <= '0;
         stage_q <= '0;
         armed_q <= 1'b0;
         wr_q    <= 1'b1;
      end else begin
         wr_q <= wr_n;
         if (wr_active) begin
            stage_q <= data;
            armed_q <= 1'b1;
         end else if (wr_rise) begin
            if (armed_q) sel_reg <= stage_q;
            armed_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/ssq_sel_path.sv
module ssq_sel_path #(
   parameter int NUM_CH = 4
) (
   input  logic              mode,
   input  logic [NUM_CH-1:0] pins,
   input  logic [NUM_CH-1:0] sel_reg,
   output logic [NUM_CH-1:0] sel_live,
   output logic              ext_clk,
   output logic              clk_src_ext
);
   timeunit 1ns;
   timeprecision 100ps;

   // Transparent source mux; freezing happens in the stepper at start
   assign sel_live = mode ? sel_reg : pins;

   generate
      if (NUM_CH >= 2) begin : g_reuse
         assign ext_clk     = mode & pins[0];
         assign clk_src_ext = mode & pins[1];
      end else begin : g_noreuse
         assign ext_clk     = 1'b0;
         assign clk_src_ext = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/ssq_stepper.sv
module ssq_stepper
   import ssq_pkg::*;
#(
   parameter int NUM_CH      = 4,
   parameter int CONV_CYCLES = 8,
   localparam int IDX_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int CNT_W      = $clog2(CONV_CYCLES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [NUM_CH-1:0] sel_i,
   output logic [NUM_CH-1:0] hold_o,
   output logic              busy_o,
   output logic              eoc_n_o,
   output logic              eng_start_o,
   output logic [IDX_W-1:0]  chan_idx_o
);
   timeunit 1ns;
   timeprecision 100ps;

   step_t             state_q;
   logic [NUM_CH-1:0] rem_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              start_q;
   logic              start_rise;
   logic [NUM_CH-1:0] low_mask;
   logic [IDX_W-1:0]  low_idx;

   assign start_rise = start_i && !start_q;
   // isolate lowest pending channel
   assign low_mask   = rem_q & (~rem_q + 1'b1);

   always_comb begin
      low_idx = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (rem_q[i]) low_idx = IDX_W'(i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         rem_q       <= '0;
         cnt_q       <= '0;
         start_q     <= 1'b0;
         hold_o      <= '0;
         busy_o      <= 1'b0;
         eoc_n_o     <= 1'b1;
         eng_start_o <= 1'b0;
         chan_idx_o  <= '0;
      end else begin
         start_q     <= start_i;
         eoc_n_o     <= 1'b1;
         eng_start_o <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_rise) begin
                  rem_q   <= sel_i;
                  busy_o  <= 1'b1;
                  hold_o  <= '1;
                  state_q <= ST_PICK;
               end
            end
            ST_PICK: begin
               if (rem_q == '0) begin
                  busy_o  <= 1'b0;
                  hold_o  <= '0;
                  state_q <= ST_IDLE;
               end else begin
                  chan_idx_o  <= low_idx;
                  rem_q       <= rem_q & ~low_mask;
                  eng_start_o <= 1'b1;
                  cnt_q       <= CNT_W'(CONV_CYCLES - 1);
                  state_q     <= ST_CONV;
               end
            end
            ST_CONV: begin
               if (cnt_q == '0) begin
                  eoc_n_o <= 1'b0;
                  state_q <= ST_PICK;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ssq_sequencer.sv
module ssq_sequencer #(
   parameter int NUM_CH      = 4,
   parameter int CONV_CYCLES = 8,
   localparam int IDX_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              sel_mode_i,
   input  logic [NUM_CH-1:0] sel_pins_i,
   input  logic              bus_cs_n_i,
   input  logic              bus_wr_n_i,
   input  logic              bus_rd_n_i,
   input  logic [NUM_CH-1:0] bus_data_i,
   output logic [NUM_CH-1:0] hold_o,
   output logic              busy_o,
   output logic              eoc_n_o,
   output logic              eng_start_o,
   output logic [IDX_W-1:0]  chan_idx_o,
   output logic              ext_clk_o,
   output logic              clk_src_ext_o
);
   timeunit 1ns;
   timeprecision 100ps;

   generate
      if (NUM_CH < 2) begin : g_bad_ch
         $error("ssq_sequencer: NUM_CH must be at least 2");
      end
      if (CONV_CYCLES < 1) begin : g_bad_cyc
         $error("ssq_sequencer: CONV_CYCLES must be at least 1");
      end
   endgenerate

   logic [NUM_CH-1:0] sel_reg;
   logic [NUM_CH-1:0] sel_live;

   ssq_sel_reg #(.NUM_CH(NUM_CH)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_n    (bus_cs_n_i),
      .wr_n    (bus_wr_n_i),
      .rd_n    (bus_rd_n_i),
      .data    (bus_data_i),
      .sel_reg (sel_reg)
   );

   ssq_sel_path #(.NUM_CH(NUM_CH)) u_path (
      .mode        (sel_mode_i),
      .pins        (sel_pins_i),
      .sel_reg     (sel_reg),
      .sel_live    (sel_live),
      .ext_clk     (ext_clk_o),
      .clk_src_ext (clk_src_ext_o)
   );

   ssq_stepper #(.NUM_CH(NUM_CH), .CONV_CYCLES(CONV_CYCLES)) u_step (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .sel_i       (sel_live),
      .hold_o      (hold_o),
      .busy_o      (busy_o),
      .eoc_n_o     (eoc_n_o),
      .eng_start_o (eng_start_o),
      .chan_idx_o  (chan_idx_o)
   );
endmodule

// File: rtl/ssq_checker.sv
module ssq_checker #(
   parameter int NUM_CH      = 4,
   parameter int CONV_CYCLES = 8,
   localparam int IDX_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int GAP_W      = $clog2(CONV_CYCLES + 2) + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [NUM_CH-1:0] hold_o,
   input logic              busy_o,
   input logic              eoc_n_o,
   input logic              eng_start_o,
   input logic [IDX_W-1:0]  chan_idx_o
);
   timeunit 1ns;
   timeprecision 100ps;

   logic [GAP_W-1:0] gap_q;
   logic [IDX_W-1:0] last_idx_q;
   logic             seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q      <= '0;
         last_idx_q <= '0;
         seen_q     <= 1'b0;
      end else begin
         if (eng_start_o)        gap_q <= GAP_W'(1);
         else if (!eoc_n_o)      gap_q <= '0;
         else if (gap_q != '0)   gap_q <= gap_q + 1'b1;
         if (!busy_o) begin
            seen_q <= 1'b0;
         end else if (eng_start_o) begin
            seen_q     <= 1'b1;
            last_idx_q <= chan_idx_o;
         end
      end
   end

   // R2: start edge while idle puts everything into hold
   a_r2_start_holds: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(start_i) && !busy_o |=> busy_o && (hold_o == '1));

   // R5: hold controls move with busy
   a_r5_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (hold_o == '1));
   a_r5_track_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (hold_o == '0));

   // R4: one-cycle end-of-conversion, inside busy, after CONV_CYCLES
   a_r4_eoc_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      !eoc_n_o |=> eoc_n_o);
   a_r4_eoc_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !eoc_n_o |-> busy_o);
   a_r4_eoc_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      !eoc_n_o |-> gap_q == GAP_W'(CONV_CYCLES));

   // R3: strobes are single cycle, inside busy, ascending
   a_r3_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start_o |=> !eng_start_o);
   a_r3_strobe_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start_o |-> busy_o);
   a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start_o && seen_q |-> chan_idx_o > last_idx_q);
endmodule

bind ssq_sequencer ssq_checker #(.NUM_CH(NUM_CH), .CONV_CYCLES(CONV_CYCLES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .hold_o      (hold_o),
   .busy_o      (busy_o),
   .eoc_n_o     (eoc_n_o),
   .eng_start_o (eng_start_o),
   .chan_idx_o  (chan_idx_o)
);

// File: tb/ssq_sequencer_bench.sv
module ssq_sequencer_bench;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int NC = 4;
   localparam int N  = 5;
   localparam int NV = 6;
   // vector: {mode, pins[3:0], reg[3:0]}
   localparam logic [8:0] VEC [NV] = '{
      {1'b0, 4'b1101, 4'b0000},
      {1'b0, 4'b1000, 4'b0110},
      {1'b0, 4'b1111, 4'b0000},
      {1'b1, 4'b1111, 4'b0101},
      {1'b1, 4'b0000, 4'b1010},
      {1'b1, 4'b0110, 4'b1001}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, mode = 1'b0, cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
   logic [NC-1:0] pins = '0, data = '0;
   logic [NC-1:0] hold;
   logic busy, eoc_n, eng_start, ext_clk, clk_src;
   logic [1:0] chan_idx;

   int checks = 0, fails = 0;
   bit mon = 1'b0;
   int cyc = 0, busy_len, n_starts, n_eoc, gap_bad, last_st, ord_act;

   always #2.5 clk = ~clk;

   ssq_sequencer #(.NUM_CH(NC), .CONV_CYCLES(N)) u_ssq_sequencer (
      .clk(clk), .rst_n(rst_n), .start_i(start), .sel_mode_i(mode),
      .sel_pins_i(pins), .bus_cs_n_i(cs_n), .bus_wr_n_i(wr_n),
      .bus_rd_n_i(rd_n), .bus_data_i(data), .hold_o(hold), .busy_o(busy),
      .eoc_n_o(eoc_n), .eng_start_o(eng_start), .chan_idx_o(chan_idx),
      .ext_clk_o(ext_clk), .clk_src_ext_o(clk_src)
   );

   always @(negedge clk) begin
      if (mon) begin
         if (busy) busy_len++;
         if (eng_start) begin
            if (n_starts < 8) ord_act |= (int'(chan_idx) + 1) << (4 * n_starts);
            n_starts++;
            last_st = cyc;
         end
         if (!eoc_n) begin
            n_eoc++;
            if (cyc - last_st != N) gap_bad++;
         end
      end
      cyc++;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [NC-1:0] v, input logic cs_v, input logic rd_v);
      @(negedge clk); cs_n = cs_v; rd_n = rd_v; data = v; wr_n = 1'b0;
      @(negedge clk); wr_n = 1'b1;
      @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
   endtask

   // action: 0 none, 1 second start mid-run, 2 pins/mode change mid-run
   task automatic run_seq(input logic [NC-1:0] mask, input int action, input string req);
      int k = 0, exp_ord = 0;
      for (int i = 0; i < NC; i++)
         if (mask[i]) begin exp_ord |= (i + 1) << (4 * k); k++; end
      busy_len = 0; n_starts = 0; n_eoc = 0; gap_bad = 0; ord_act = 0; last_st = 0;
      mon = 1'b1;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      for (int i = 0; i < 4 * (N + 1) + 6; i++) begin
         @(negedge clk);
         if (i == 6 && action == 1) start = 1'b1;
         if (i == 7 && action == 1) start = 1'b0;
         if (i == 6 && action == 2) begin pins = 4'b1111; mode = ~mode; end
      end
      mon = 1'b0;
      chk(ord_act == exp_ord, {req, " order"}, ord_act, exp_ord);
      chk(n_eoc == k && gap_bad == 0, {req, " eoc"}, n_eoc, k);
      chk(busy_len == k * (N + 1) + 1, {req, " busy"}, busy_len, k * (N + 1) + 1);
   endtask

   initial begin : watchdog
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy && hold == '0 && eoc_n && !eng_start, "R1 during reset",
          {busy, hold, eoc_n, eng_start}, 32'b0000010);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && hold == '0 && eoc_n && !eng_start, "R1 after reset",
          {busy, hold, eoc_n, eng_start}, 32'b0000010);

      // R2 hold and busy right after the start edge
      pins = 4'b0001;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(busy && hold == '1, "R2 hold at start", {busy, hold}, 5'b11111);
      repeat (3 * (N + 1)) @(negedge clk);

      // Vector table: R3 R4 R5 R6 R7 R12 (pins 3,4 ignored in register mode)
      for (int v = 0; v < NV; v++) begin
         mode = VEC[v][8];
         pins = VEC[v][7:4];
         if (mode) bus_write(VEC[v][3:0], 1'b0, 1'b1);
         run_seq(mode ? VEC[v][3:0] : VEC[v][7:4], 0, "R3/R4/R5/R6/R7 vector");
      end

      // R7 register persists without a new write
      mode = 1'b1; pins = 4'b0011;
      run_seq(4'b1001, 0, "R7 persist");

      // R8 write ignored without chip-select or with read low
      bus_write(4'b1111, 1'b1, 1'b1);
      bus_write(4'b0010, 1'b0, 1'b0);
      run_seq(4'b1001, 0, "R8 ignored write");

      // R9 selection frozen at start
      mode = 1'b0; pins = 4'b0011;
      run_seq(4'b0011, 2, "R9 frozen");

      // R10 start during busy ignored
      mode = 1'b0; pins = 4'b1010;
      run_seq(4'b1010, 1, "R10 start in busy");

      // R11 empty selection
      pins = 4'b0000;
      run_seq(4'b0000, 0, "R11 empty");

      // R12 pin reuse outputs
      mode = 1'b1; pins = 4'b0010;
      @(negedge clk);
      chk(!ext_clk && clk_src, "R12 reg mode pin2", {ext_clk, clk_src}, 2'b01);
      pins = 4'b1101;
      @(negedge clk);
      chk(ext_clk && !clk_src, "R12 reg mode pin1", {ext_clk, clk_src}, 2'b10);
      mode = 1'b0;
      @(negedge clk);
      chk(!ext_clk && !clk_src, "R12 pin mode", {ext_clk, clk_src}, 2'b00);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule